// File: doc/BRIEF.md
# Lowest-Set-Bit and AND-NOT Execution Unit

This unit sits in the integer datapath of a processor core. It takes an operation select and two source operands, computes one of four bit-manipulation results, and returns the result with a matching set of condition flags one clock later. Three of the operations act on the lowest set bit of the first source: isolate it, build a mask that runs from bit 0 up to and including it, or clear it. The fourth computes the inverse of the first source ANDed with the second. Each result comes from a two's-complement identity on the source. The carry and zero flags follow a separate rule for each operation, and that rule has its own handling of a zero source.

The unit also selects the operand size. The narrow width applies unless long mode is active and the width select requests the full width. When the vector-length bit is set, or when the processor reports a legacy execution mode, the unit raises an invalid-opcode fault and suppresses both the result and every flag write. Decode, register-file access and memory operands are handled outside this unit.

Top module: `lsb_unit`

## Requirements
- R1: With `op_sel` = 0, the result is `~src_a & src_b`. CF and OF are 0, ZF is 1 when the result is zero, and SF is the top bit of the result.
- R2: With `op_sel` = 1, the result has only the lowest set bit of `src_a` set, or is zero when `src_a` is zero. CF is 1 exactly when the source is nonzero, and ZF and SF follow the result.
- R3: With `op_sel` = 2, the result is all ones from bit 0 up to and including the lowest set bit of `src_a`. A zero source gives all ones across the operand size with CF = 1. Any nonzero source gives CF = 0. ZF is always 0 and SF follows the result.
- R4: With `op_sel` = 3, the result is `src_a` with its lowest set bit cleared. CF is 1 only for a zero source, and ZF and SF follow the result.
- R5: The operand size is `DATA_W` only when `long_mode` = 1 and `wide_sel` = 1. Otherwise it is `NARROW_W`: source bits at or above `NARROW_W` are ignored, the result bits at or above `NARROW_W` are 0, SF is taken from bit `NARROW_W-1`, and zero tests use the narrowed source. `wide_sel` has no effect when `long_mode` = 0.
- R6: When `vec_len` = 1 or `legacy_mode` = 1, the response has `ud_fault` = 1, `result` = 0, `flags` = 0 and `flag_wr_mask` = 0.
- R7: The flag vector uses bit 0 for CF, bit 1 for ZF, bit 2 for SF, bit 3 for OF, bit 4 for AF and bit 5 for PF. On every response without a fault, OF, AF and PF are 0 and `flag_wr_mask` is all ones.
- R8: `out_valid` is high for exactly the cycle after each cycle in which `in_valid` is high. While reset is held, and after it until the first request, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | Operation: 0 and-not, 1 isolate, 2 mask, 3 clear |
| src_a | input | DATA_W | First source operand |
| src_b | input | DATA_W | Second source operand, used by and-not only |
| wide_sel | input | 1 | Requests the full operand size |
| long_mode | input | 1 | Long mode is active |
| vec_len | input | 1 | Vector-length bit; a nonzero value faults |
| legacy_mode | input | 1 | Processor is in a mode where these operations are illegal |
| out_valid | output | 1 | Response strobe |
| result | output | DATA_W | Result of the operation |
| flags | output | 6 | Flag values: CF, ZF, SF, OF, AF, PF from bit 0 upward |
| flag_wr_mask | output | 6 | Flags to be written back, same bit order as `flags` |
| ud_fault | output | 1 | Invalid-opcode fault |

## Verification
The bench builds the unit with `DATA_W` = 8 and `NARROW_W` = 4, so every source value can be swept.
- The three single-source operations see all 256 values of `src_a` in the wide size and in both narrow configurations.
- The narrow sweep covers the zero source on a truncated operand, which exercises the zero-source carry rules, and the discard of upper source bits.
- The and-not operation is swept over all first operands against sixteen second operands.
- The fault conditions are applied alone and together.

// File: rtl/lsb_pkg.sv
// Package: shared types for the lowest-set-bit unit.
// Holds the operation encoding and the flag bit positions that the unit's
// consumers decode. Assumes a six-entry flag vector.
package lsb_pkg;

    typedef enum logic [1:0] {
        OP_ANDNOT  = 2'd0,
        OP_ISOLATE = 2'd1,
        OP_MASK    = 2'd2,
        OP_CLEAR   = 2'd3
    } lsb_op_e;

    localparam int FLG_CF = 0;
    localparam int FLG_ZF = 1;
    localparam int FLG_SF = 2;
    localparam int FLG_OF = 3;
    localparam int FLG_AF = 4;
    localparam int FLG_PF = 5;
    localparam int FLG_N  = 6;

endpackage

// File: rtl/lsb_size_ctrl.sv
// Module: lsb_size_ctrl
// Picks the effective operand size, narrows both sources to it and
// detects the illegal-request conditions.
// Assumes NARROW_W < DATA_W.
module lsb_size_ctrl #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              wide_sel,
    input  logic              long_mode,
    input  logic              vec_len,
    input  logic              legacy_mode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              is_wide,
    output logic              fault,
    output logic [DATA_W-1:0] keep_mask,
    output logic [DATA_W-1:0] a_eff,
    output logic [DATA_W-1:0] b_eff
);

    // The width select counts only in long mode.
    always_comb is_wide = long_mode & wide_sel;

    // Either the vector-length bit or a legacy mode makes the request illegal.
    always_comb fault = vec_len | legacy_mode;

    // Each bit of the mask keeps either a low lane or, in wide size, every lane.
    for (genvar i = 0; i < DATA_W; i++) begin : g_keep
        if (i < NARROW_W) begin : g_low
            assign keep_mask[i] = 1'b1;
        end else begin : g_high
            assign keep_mask[i] = is_wide;
        end
    end

    // Both sources are truncated to the effective size.
    always_comb begin
        a_eff = src_a & keep_mask;
        b_eff = src_b & keep_mask;
    end

endmodule

// File: rtl/lsb_alu.sv
// Module: lsb_alu
// Forms the four results from two's-complement identities on the narrowed
// sources. Assumes the sources are already zero above the effective size.
module lsb_alu #(
    parameter int DATA_W = 64
) (
    input  lsb_pkg::lsb_op_e  op,
    input  logic [DATA_W-1:0] a_eff,
    input  logic [DATA_W-1:0] b_eff,
    input  logic [DATA_W-1:0] keep_mask,
    output logic [DATA_W-1:0] res,
    output logic              src_zero
);
    import lsb_pkg::*;

    logic [DATA_W-1:0] a_neg;
    logic [DATA_W-1:0] a_dec;
    logic [DATA_W-1:0] raw;

    // Negation and decrement are the shared arithmetic terms.
    always_comb begin
        a_neg = '0 - a_eff;
        a_dec = a_eff - 1'b1;
    end

    // The zero test on the first source drives the carry rules.
    always_comb src_zero = (a_eff == '0);

    // Selects the identity for the requested operation.
    always_comb begin
        unique case (op)
            OP_ANDNOT:  raw = ~a_eff & b_eff;
            OP_ISOLATE: raw = a_neg & a_eff;
            OP_MASK:    raw = a_dec ^ a_eff;
            OP_CLEAR:   raw = a_dec & a_eff;
            default:    raw = '0;
        endcase
    end

    // Bits above the effective size are cleared.
    always_comb res = raw & keep_mask;

endmodule

// File: rtl/lsb_flag_gen.sv
// Module: lsb_flag_gen
// Derives the six-bit flag vector from the result and the source-zero test.
// Assumes res is already zero above the effective size.
module lsb_flag_gen #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  lsb_pkg::lsb_op_e          op,
    input  logic [DATA_W-1:0]         res,
    input  logic                      src_zero,
    input  logic                      is_wide,
    output logic [lsb_pkg::FLG_N-1:0] flg
);
    import lsb_pkg::*;

    logic carry;
    logic zero;
    logic sign;

    // The carry rule depends on the operation.
    always_comb begin
        unique case (op)
            OP_ANDNOT:  carry = 1'b0;
            OP_ISOLATE: carry = ~src_zero;
            OP_MASK:    carry = src_zero;
            OP_CLEAR:   carry = src_zero;
            default:    carry = 1'b0;
        endcase
    end

    // The mask operation always clears ZF; the others test the result.
    always_comb zero = (op == OP_MASK) ? 1'b0 : (res == '0);

    // The sign comes from the top bit of the effective size.
    always_comb sign = is_wide ? res[DATA_W-1] : res[NARROW_W-1];

    // OF is cleared; AF and PF are driven to zero deterministically.
    always_comb begin
        flg         = '0;
        flg[FLG_CF] = carry;
        flg[FLG_ZF] = zero;
        flg[FLG_SF] = sign;
    end

endmodule

// File: rtl/lsb_unit.sv
// Module: lsb_unit (top)
// Computes and-not, lowest-bit isolate, lowest-bit mask or lowest-bit
// clear, and registers the result, flags, flag write mask and fault one
// cycle after in_valid. Assumes one request per cycle at most and
// NARROW_W < DATA_W.
module lsb_unit #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              wide_sel,
    input  logic              long_mode,
    input  logic              vec_len,
    input  logic              legacy_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [5:0]        flags,
    output logic [5:0]        flag_wr_mask,
    output logic              ud_fault
);
    import lsb_pkg::*;

    localparam int NF = FLG_N;

    lsb_op_e           op;
    logic              is_wide;
    logic              fault;
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] a_eff;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] res;
    logic              src_zero;
    logic [NF-1:0]     flg;

    // The operation select is decoded into the shared encoding.
    always_comb op = lsb_op_e'(op_sel);

    lsb_size_ctrl #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_size (
        .wide_sel   (wide_sel),
        .long_mode  (long_mode),
        .vec_len    (vec_len),
        .legacy_mode(legacy_mode),
        .src_a      (src_a),
        .src_b      (src_b),
        .is_wide    (is_wide),
        .fault      (fault),
        .keep_mask  (keep_mask),
        .a_eff      (a_eff),
        .b_eff      (b_eff)
    );

    lsb_alu #(.DATA_W(DATA_W)) i_alu (
        .op       (op),
        .a_eff    (a_eff),
        .b_eff    (b_eff),
        .keep_mask(keep_mask),
        .res      (res),
        .src_zero (src_zero)
    );

    lsb_flag_gen #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_flags (
        .op      (op),
        .res     (res),
        .src_zero(src_zero),
        .is_wide (is_wide),
        .flg     (flg)
    );

    // The output stage captures one response per request and suppresses it on a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            flags        <= '0;
            flag_wr_mask <= '0;
            ud_fault     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                ud_fault     <= fault;
                result       <= fault ? '0 : res;
                flags        <= fault ? '0 : flg;
                flag_wr_mask <= fault ? '0 : {NF{1'b1}};
            end
        end
    end

endmodule

// File: rtl/lsb_unit_chk.sv
// Module: lsb_unit_chk
// Checker bound to lsb_unit. It relates the registered outputs to the
// request inputs of the cycle before. Assumes NARROW_W < DATA_W.
module lsb_unit_chk #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        op_sel,
    input logic              wide_sel,
    input logic              long_mode,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic [5:0]        flags,
    input logic [5:0]        flag_wr_mask,
    input logic              ud_fault
);

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    valid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ud_fault) |-> (result == '0 && flag_wr_mask == 6'd0 && flags == 6'd0));

    // R7
    clean_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !ud_fault) |-> (flags[5:3] == 3'b000 && flag_wr_mask == 6'h3F));

    // R3
    mask_zf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd2) |=> (ud_fault || !flags[1]));

    // R2
    isolate_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd1) |=> $onehot0(result));

    // R5
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(long_mode && wide_sel)) |=> ((result >> NARROW_W) == '0));

endmodule

bind lsb_unit lsb_unit_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_lsb_unit_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_sel      (op_sel),
    .wide_sel    (wide_sel),
    .long_mode   (long_mode),
    .out_valid   (out_valid),
    .result      (result),
    .flags       (flags),
    .flag_wr_mask(flag_wr_mask),
    .ud_fault    (ud_fault)
);

// File: tb/test_lsb_unit.sv
// Bench for lsb_unit built with an 8-bit full width and a 4-bit narrow
// width. It sweeps the sources and compares against an arithmetic model.
module test_lsb_unit;

    localparam int DW = 8;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    op_sel = 2'd0;
    logic [DW-1:0] src_a = '0;
    logic [DW-1:0] src_b = '0;
    logic          wide_sel = 1'b0;
    logic          long_mode = 1'b0;
    logic          vec_len = 1'b0;
    logic          legacy_mode = 1'b0;
    logic          out_valid;
    logic [DW-1:0] result;
    logic [5:0]    flags;
    logic [5:0]    flag_wr_mask;
    logic          ud_fault;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    lsb_unit #(.DATA_W(DW), .NARROW_W(NW)) i_lsb_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .src_a(src_a), .src_b(src_b), .wide_sel(wide_sel), .long_mode(long_mode),
        .vec_len(vec_len), .legacy_mode(legacy_mode), .out_valid(out_valid),
        .result(result), .flags(flags), .flag_wr_mask(flag_wr_mask), .ud_fault(ud_fault)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // The model works from the requirements: it searches for the lowest set bit.
    task automatic model(input logic [1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input bit wide, output logic [DW-1:0] r, output logic [5:0] f);
        int w;
        int idx;
        logic [DW-1:0] keep;
        logic [DW-1:0] sa;
        logic [DW-1:0] sb;
        logic cf;
        logic zf;
        w    = wide ? DW : NW;
        keep = DW'((1 << w) - 1);
        sa   = a & keep;
        sb   = b & keep;
        idx  = -1;
        for (int i = w - 1; i >= 0; i--) if (sa[i]) idx = i;
        case (op)
            2'd0: begin r = ~sa & sb & keep; cf = 1'b0; zf = (r == 0); end
            2'd1: begin r = (idx >= 0) ? DW'(1 << idx) : '0; cf = (idx >= 0); zf = (r == 0); end
            2'd2: begin r = (idx >= 0) ? DW'((1 << (idx + 1)) - 1) : keep; cf = (idx < 0); zf = 1'b0; end
            default: begin r = (idx >= 0) ? (sa & ~DW'(1 << idx)) : '0; cf = (idx < 0); zf = (r == 0); end
        endcase
        f = {3'b000, r[w-1], zf, cf};
    endtask

    // Issues one request at a falling edge and checks the response one cycle later.
    task automatic run_op(input logic [1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input bit lm, input bit ws);
        logic [DW-1:0] er;
        logic [5:0] ef;
        string tag;
        bit wide;
        wide = lm && ws;
        model(op, a, b, wide, er, ef);
        case (op)
            2'd0: tag = "R1";
            2'd1: tag = "R2";
            2'd2: tag = "R3";
            default: tag = "R4";
        endcase
        if (!wide) tag = {tag, "/R5"};
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; src_a = a; src_b = b; long_mode = lm; wide_sel = ws;
        vec_len = 1'b0; legacy_mode = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " result"}, 32'(result), 32'(er));
        check({tag, " flags"}, 32'(flags), 32'(ef));
        check("R7 write mask and fault", 32'({flag_wr_mask, ud_fault}), 32'({6'h3F, 1'b0}));
        check("R8 out_valid", 32'(out_valid), 32'd1);
    endtask

    // Issues an illegal request and checks that the response is suppressed.
    task automatic run_fault(input logic vl, input logic lg, input logic [1:0] op, input logic [DW-1:0] a);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; src_a = a; src_b = 8'hA5; long_mode = 1'b1; wide_sel = 1'b1;
        vec_len = vl; legacy_mode = lg;
        @(negedge clk);
        in_valid = 1'b0; vec_len = 1'b0; legacy_mode = 1'b0;
        check("R6 fault", 32'(ud_fault), 32'd1);
        check("R6 suppressed", 32'({result, flags, flag_wr_mask}), 32'd0);
        check("R8 fault valid", 32'(out_valid), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset outputs", 32'({out_valid, result, flags, flag_wr_mask, ud_fault}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle after reset", 32'({out_valid, result, ud_fault}), 32'd0);
        // Corner cases called out by the requirements.
        run_op(2'd2, 8'h00, 8'h00, 1'b1, 1'b1);
        run_op(2'd2, 8'hF0, 8'h00, 1'b1, 1'b0);
        run_op(2'd1, 8'h80, 8'h00, 1'b1, 1'b1);
        run_op(2'd3, 8'h00, 8'h00, 1'b0, 1'b1);
        // Sweeps over the three size configurations.
        for (int cfg = 0; cfg < 3; cfg++) begin
            bit lm;
            bit ws;
            lm = (cfg != 2);
            ws = (cfg != 1);
            for (int op = 1; op < 4; op++)
                for (int a = 0; a < 256; a++)
                    run_op(2'(op), 8'(a), 8'(a * 37), lm, ws);
            for (int a = 0; a < 256; a++)
                for (int k = 0; k < 16; k++)
                    run_op(2'd0, 8'(a), 8'((k * 17) ^ 8'h5A), lm, ws);
        end
        run_fault(1'b1, 1'b0, 2'd1, 8'h0C);
        run_fault(1'b0, 1'b1, 2'd2, 8'h00);
        run_fault(1'b1, 1'b1, 2'd0, 8'h3C);
        @(negedge clk);
        check("R8 idle drop", 32'(out_valid), 32'd0);
        run_op(2'd3, 8'h6C, 8'h00, 1'b1, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule